// File: doc/BRIEF.md
# Processor Mode Control Register

This block is a single-byte control register on a simple synchronous bus. It holds five settings: the processor operating mode, the interrupt priority detection window, the external-access wait control, a software reset trigger and the enable that puts the system clock on a shared port pin. A bus write to the configured byte address updates the fields. A read from that address returns them on the same cycle.

The outputs go to neighbouring logic. A one-cycle reset request pulses after a reset trigger is written. A wait-insert flag tells the bus cycle generator to stretch external accesses. A small binary count (7, 4 or 2) gives the interrupt arbiter its detection window. A port-pin multiplexer picks between a general-purpose output value and the raw clock. Microprocessor mode always drives the clock onto the pin. A strap input forces the upper mode bit high, so the part comes out of reset in microprocessor mode.

Top module: `pmode_ctrl_reg`

## Requirements
- R1: After reset with the strap low, a read at the register address returns 0x00, the detection count is 7, the wait-insert flag is 1, the reset request is 0, and the pin follows the general-purpose output.
- R2: The mode field occupies bits 1:0 (00 single-chip, 01 memory expansion, 10 microprocessor). A write of the reserved code 11 leaves the previous mode in place.
- R3: The detection field occupies bits 5:4 and maps to a count: 00 gives 7, 01 gives 4, 10 gives 2. A write of the reserved code 11 leaves the previous field and count in place.
- R4: Bit 2 is the wait bit, and the wait-insert output is its inverse: 0 inserts a wait, 1 does not.
- R5: A write with bit 3 set raises the reset request for exactly the one cycle after the write. Bit 3 always reads 0. On the clock edge that ends the pulse, every field returns to its reset value.
- R6: Bit 6 ignores written data and always reads 0.
- R7: In single-chip and memory-expansion modes, the pin carries the clock only while bit 7 is 1. Otherwise it carries the general-purpose output value.
- R8: In microprocessor mode, the pin carries the clock whatever the value of bit 7.
- R9: While the strap is high, reset leaves the mode at 10 and bit 1 always reads 1. A write whose mode, with bit 1 forced to 1, would become 11 is rejected.
- R10: Writes to any other address change nothing, and reads at any other address return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the source driven onto the pin |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 8 | Read data for the current address (combinational) |
| strap_mp | input | 1 | Strap forcing mode bit 1 high |
| gpio_out | input | 1 | General-purpose value for the shared pin |
| pin_out | output | 1 | Shared pin: clock or general-purpose value |
| swrst_req | output | 1 | One-cycle software reset request |
| wait_insert | output | 1 | 1 when external accesses need a wait |
| detect_cycles | output | 3 | Interrupt priority detection window in cycles |

## Verification
The hardest state to reach from the ports is the strap case. In that case the stored mode and the visible mode differ, and a legal-looking write such as 01 turns into the reserved code. The bench reaches it by raising the strap before a reset and then writing 00, 01 and 0x80, checking the read-back and the pin after each write. The soft reset is also awkward to observe: its pulse and the field clear fall on consecutive cycles, so the bench samples the register between those two edges and again after the second.

// File: rtl/pmode_pkg.sv
// Package: shared field positions, mode encoding and the detection-count
// mapping for the processor mode control register.
// Assumes an 8-bit data bus.
package pmode_pkg;
    localparam int DATA_W    = 8;
    localparam int DET_CNT_W = 3;

    localparam int BIT_MODE_LO = 0;
    localparam int BIT_WAIT    = 2;
    localparam int BIT_SWRST   = 3;
    localparam int BIT_DET_LO  = 4;
    localparam int BIT_CLKSEL  = 7;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'b00,
        MODE_EXPAND = 2'b01,
        MODE_MPU    = 2'b10,
        MODE_RSVD   = 2'b11
    } pm_mode_e;

    typedef struct packed {
        logic       clk_sel;
        logic [1:0] det_sel;
        logic       wait_bit;
        logic [1:0] mode;
    } pm_fields_t;

    // Maps the detection select code to the window length in cycles.
    function automatic logic [DET_CNT_W-1:0] det_count(input logic [1:0] code);
        case (code)
            2'b01:   det_count = DET_CNT_W'(4);
            2'b10:   det_count = DET_CNT_W'(2);
            default: det_count = DET_CNT_W'(7);
        endcase
    endfunction
endpackage

// File: rtl/pmode_field_store.sv
// Module: pmode_field_store
// Holds the writable fields. Reserved codes are rejected per field. The
// strap forces mode bit 1 high, both at reset and on every write.
// Assumes wr_en is already qualified by the address decode. soft_clr has
// priority over a write in the same cycle.
module pmode_field_store
    import pmode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              strap,
    output pm_fields_t        fields,
    output logic [1:0]        mode_eff
);
    pm_fields_t fields_q;
    logic [1:0] mode_cand;
    logic [1:0] det_cand;

    // Candidate field values taken from the write data.
    always_comb begin
        mode_cand = {wdata[BIT_MODE_LO+1] | strap, wdata[BIT_MODE_LO]};
        det_cand  = wdata[BIT_DET_LO +: 2];
    end

    // Field registers: reset, soft clear, or a write with reserved codes held.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            fields_q.mode     <= strap ? MODE_MPU : MODE_SINGLE;
            fields_q.det_sel  <= 2'b00;
            fields_q.wait_bit <= 1'b0;
            fields_q.clk_sel  <= 1'b0;
        end else if (wr_en) begin
            if (mode_cand != MODE_RSVD) fields_q.mode <= mode_cand;
            if (det_cand != 2'b11)      fields_q.det_sel <= det_cand;
            fields_q.wait_bit <= wdata[BIT_WAIT];
            fields_q.clk_sel  <= wdata[BIT_CLKSEL];
        end
    end

    // Visible mode: the strap overrides bit 1.
    always_comb begin
        fields   = fields_q;
        mode_eff = {fields_q.mode[1] | strap, fields_q.mode[0]};
    end
endmodule

// File: rtl/pmode_rst_pulse.sv
// Module: pmode_rst_pulse
// Produces a one-cycle reset request on the cycle after a write with the
// trigger bit set. The trigger itself is not stored.
// Assumes wr_en is already qualified by the address decode.
module pmode_rst_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic trig_bit,
    output logic req
);
    // Registers the trigger and clears it after one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) req <= 1'b0;
        else        req <= wr_en & trig_bit & ~req;
    end
endmodule

// File: rtl/pmode_pin_mux.sv
// Module: pmode_pin_mux
// Chooses what drives the shared pin. Microprocessor mode forces the clock;
// the other modes follow the clock-select bit. The selection is not aligned
// to the clock phase, so the first clock pulse on the pin may be short.
// Assumes the pin consumer tolerates that runt pulse.
module pmode_pin_mux
    import pmode_pkg::*;
(
    input  logic       clk_src,
    input  logic [1:0] mode_eff,
    input  logic       clk_sel,
    input  logic       gpio_val,
    output logic       drive_clk,
    output logic       pin
);
    // Clock-drive decision followed by the pin multiplexer.
    always_comb begin
        drive_clk = (mode_eff == MODE_MPU) | clk_sel;
        pin       = drive_clk ? clk_src : gpio_val;
    end
endmodule

// File: rtl/pmode_ctrl_reg.sv
// Module: pmode_ctrl_reg (top)
// Byte-wide processor mode control register with address decode, read-back
// assembly, soft reset request, wait flag, detection count and pin mux.
// Assumes single-cycle writes and combinational reads on a synchronous bus.
module pmode_ctrl_reg
    import pmode_pkg::*;
#(
    parameter int               ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'('h5E)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    input  logic                 bus_we,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic                 strap_mp,
    input  logic                 gpio_out,
    output logic                 pin_out,
    output logic                 swrst_req,
    output logic                 wait_insert,
    output logic [DET_CNT_W-1:0] detect_cycles
);
    logic       hit;
    logic       wr_en;
    pm_fields_t fields;
    logic [1:0] mode_eff;
    logic       clk_drive;

    // Address decode and write qualification.
    always_comb begin
        hit   = (bus_addr == REG_ADDR);
        wr_en = hit & bus_we;
    end

    pmode_field_store u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (swrst_req),
        .wr_en    (wr_en),
        .wdata    (bus_wdata),
        .strap    (strap_mp),
        .fields   (fields),
        .mode_eff (mode_eff)
    );

    pmode_rst_pulse u_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .trig_bit (bus_wdata[BIT_SWRST]),
        .req      (swrst_req)
    );

    pmode_pin_mux u_mux (
        .clk_src   (clk),
        .mode_eff  (mode_eff),
        .clk_sel   (fields.clk_sel),
        .gpio_val  (gpio_out),
        .drive_clk (clk_drive),
        .pin       (pin_out)
    );

    // Read-back assembly; bits 6 and 3 always read 0.
    always_comb begin
        bus_rdata = '0;
        if (hit) begin
            bus_rdata[BIT_CLKSEL]        = fields.clk_sel;
            bus_rdata[BIT_DET_LO +: 2]   = fields.det_sel;
            bus_rdata[BIT_WAIT]          = fields.wait_bit;
            bus_rdata[BIT_MODE_LO +: 2]  = mode_eff;
        end
    end

    // Side outputs for the bus cycle generator and the interrupt arbiter.
    always_comb begin
        wait_insert   = ~fields.wait_bit;
        detect_cycles = det_count(fields.det_sel);
    end
endmodule

// File: rtl/pmode_ctrl_reg_chk.sv
// Module: pmode_ctrl_reg_chk
// Assertion checker bound into pmode_ctrl_reg. It watches ports and the
// signals that connect the submodules.
module pmode_ctrl_reg_chk #(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'('h5E)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              bus_we,
    input logic [7:0]        bus_rdata,
    input logic              strap_mp,
    input logic              gpio_out,
    input logic              pin_out,
    input logic              swrst_req,
    input logic              wait_insert,
    input logic [2:0]        detect_cycles,
    input logic [1:0]        mode_eff,
    input logic              clk_drive
);
    // R5
    req_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swrst_req |=> !swrst_req);

    // R5
    req_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swrst_req |=> (detect_cycles == 3'd7 && wait_insert));

    // R3
    det_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (detect_cycles == 3'd7 || detect_cycles == 3'd4 || detect_cycles == 3'd2));

    // R4
    wait_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == REG_ADDR && !swrst_req) |=> (wait_insert == !$past(bus_wdata[2])));

    // R2
    mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strap_mp |-> (mode_eff != 2'b11));

    // R8
    mpu_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_eff == 2'b10) |-> clk_drive);

    // R7
    gpio_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_drive |-> (pin_out == gpio_out));

    // R10
    miss_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != REG_ADDR) |-> (bus_rdata == 8'h00));

    // R6
    bit6_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[6] == 1'b0 && bus_rdata[3] == 1'b0);
endmodule

bind pmode_ctrl_reg pmode_ctrl_reg_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_we        (bus_we),
    .bus_rdata     (bus_rdata),
    .strap_mp      (strap_mp),
    .gpio_out      (gpio_out),
    .pin_out       (pin_out),
    .swrst_req     (swrst_req),
    .wait_insert   (wait_insert),
    .detect_cycles (detect_cycles),
    .mode_eff      (mode_eff),
    .clk_drive     (clk_drive)
);

// File: tb/sim_pmode_ctrl_reg.sv
// Directed bench for pmode_ctrl_reg: one task per scenario, each checking
// its own results. Inputs change on the falling edge and are sampled there.
module sim_pmode_ctrl_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_we = 1'b0;
    logic [7:0] bus_rdata;
    logic       strap_mp = 1'b0;
    logic       gpio_out = 1'b0;
    logic       pin_out;
    logic       swrst_req;
    logic       wait_insert;
    logic [2:0] detect_cycles;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    localparam logic [7:0] RA = 8'h5E;

    always #5 clk = ~clk;

    pmode_ctrl_reg u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .strap_mp(strap_mp),
        .gpio_out(gpio_out), .pin_out(pin_out), .swrst_req(swrst_req),
        .wait_insert(wait_insert), .detect_cycles(detect_cycles)
    );

    task automatic chk(input string req, input string what, input int act, input int exp_v);
        n_chk++;
        if (act != exp_v) begin
            n_bad++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, act, exp_v);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bus_we = 1'b0;
        bus_addr = RA;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Single-cycle write; returns on the falling edge after the write edge.
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_wdata = d;
        bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        bus_addr = RA;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp_v);
        bus_addr = a;
        #1;
        chk(req, "read", int'(bus_rdata), int'(exp_v));
        bus_addr = RA;
    endtask

    // Samples the pin in both clock phases with different gpio values.
    task automatic pin_chk(input string req, input bit clocked);
        gpio_out = 1'b1;
        #1;
        chk(req, "pin low phase", int'(pin_out), clocked ? 0 : 1);
        @(posedge clk);
        gpio_out = 1'b0;
        #1;
        chk(req, "pin high phase", int'(pin_out), clocked ? 1 : 0);
        @(negedge clk);
    endtask

    task automatic t_reset();
        strap_mp = 1'b0;
        do_reset();
        rd_chk("R1", RA, 8'h00);
        chk("R1", "detect", int'(detect_cycles), 7);
        chk("R1", "wait_insert", int'(wait_insert), 1);
        chk("R1", "swrst_req", int'(swrst_req), 0);
        pin_chk("R1", 1'b0);
    endtask

    task automatic t_mode();
        wr(RA, 8'h01); rd_chk("R2", RA, 8'h01);
        wr(RA, 8'h03); rd_chk("R2", RA, 8'h01);
        wr(RA, 8'h00); rd_chk("R2", RA, 8'h00);
    endtask

    task automatic t_detect();
        wr(RA, 8'h10); rd_chk("R3", RA, 8'h10);
        chk("R3", "detect 01", int'(detect_cycles), 4);
        wr(RA, 8'h20); chk("R3", "detect 10", int'(detect_cycles), 2);
        wr(RA, 8'h30); rd_chk("R3", RA, 8'h20);
        chk("R3", "detect 11 held", int'(detect_cycles), 2);
        wr(RA, 8'h00); chk("R3", "detect 00", int'(detect_cycles), 7);
    endtask

    task automatic t_wait();
        wr(RA, 8'h04); rd_chk("R4", RA, 8'h04);
        chk("R4", "wait_insert off", int'(wait_insert), 0);
        wr(RA, 8'h00);
        chk("R4", "wait_insert on", int'(wait_insert), 1);
    endtask

    task automatic t_bit6();
        wr(RA, 8'h40); rd_chk("R6", RA, 8'h00);
        wr(RA, 8'h44); rd_chk("R6", RA, 8'h04);
        wr(RA, 8'h00);
    endtask

    task automatic t_swrst();
        wr(RA, 8'h9D);
        chk("R5", "pulse high", int'(swrst_req), 1);
        rd_chk("R5", RA, 8'h95);
        @(negedge clk);
        chk("R5", "pulse low", int'(swrst_req), 0);
        rd_chk("R5", RA, 8'h00);
        chk("R5", "detect cleared", int'(detect_cycles), 7);
    endtask

    task automatic t_clk_select();
        wr(RA, 8'h00); pin_chk("R7", 1'b0);
        wr(RA, 8'h80); pin_chk("R7", 1'b1);
        wr(RA, 8'h81); pin_chk("R7", 1'b1);
        wr(RA, 8'h01); pin_chk("R7", 1'b0);
        wr(RA, 8'h00);
    endtask

    task automatic t_mpu();
        wr(RA, 8'h02); rd_chk("R8", RA, 8'h02); pin_chk("R8", 1'b1);
        wr(RA, 8'h82); pin_chk("R8", 1'b1);
        wr(RA, 8'h00); pin_chk("R8", 1'b0);
    endtask

    task automatic t_other_addr();
        wr(RA, 8'h14);
        wr(8'h5F, 8'hB7);
        rd_chk("R10", RA, 8'h14);
        rd_chk("R10", 8'h5F, 8'h00);
        chk("R10", "no pulse", int'(swrst_req), 0);
        wr(RA, 8'h00);
    endtask

    task automatic t_strap();
        strap_mp = 1'b1;
        do_reset();
        rd_chk("R9", RA, 8'h02);
        pin_chk("R9", 1'b1);
        wr(RA, 8'h00); rd_chk("R9", RA, 8'h02);
        wr(RA, 8'h01); rd_chk("R9", RA, 8'h02);
        wr(RA, 8'h80); rd_chk("R9", RA, 8'h82);
        strap_mp = 1'b0;
        do_reset();
        rd_chk("R9", RA, 8'h00);
    endtask

    initial begin
        t_reset();
        t_mode();
        t_detect();
        t_wait();
        t_bit6();
        t_swrst();
        t_clk_select();
        t_mpu();
        t_other_addr();
        t_strap();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #1ms;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule